// File: doc/BRIEF.md
# Interrupt Poll and Branch Sequencer

This block is the cycle-timing core of a small 8-bit processor's control path. It paces each instruction one clock at a time and decides on which clock a level-sensitive maskable interrupt request is recognised. It also decides when the seven-cycle interrupt entry sequence replaces the next opcode fetch. It models timing only. Addresses, data, vectors and non-maskable interrupts are outside it.

Instruction descriptors arrive on a valid/ready stream. Ready is the opcode-fetch strobe, and a descriptor transfers only on a cycle where valid and ready are both high. While ready is high and valid is low, the sequencer waits on the fetch cycle and repeats it. Nothing is lost. The upstream side holds its descriptor until it sees ready. Each descriptor carries a base cycle count, a branch flag, a taken flag and a page-cross flag.

The key behaviour concerns conditional branches. On a taken branch that stays in its page, the extra cycle is not a poll point. On a taken branch that crosses a page, the poll moves to the page-cross cycle.

Top module: `irq_poll_seq`

## Requirements
- R1: After reset, `op_fetch` and `desc_ready` are 1, and `entry_active`, `mask_set`, `phase` and `entry_step` are 0.
- R2: A descriptor is taken only in a cycle with `desc_valid` and `desc_ready` both high. A fetch cycle without valid repeats with `phase` 0, and the next cycle after a transfer shows `phase` 1 with `op_fetch` low.
- R3: A non-branch instruction lasts `desc_cycles` cycles, with `phase` counting 0,1,...,n-1. A count below 2 or above 7 is clamped to 7.
- R4: A branch (`desc_branch`=1) lasts 2 cycles when not taken, 3 when taken in-page, and 4 when taken with `desc_xpage`=1. Its `desc_cycles` field is ignored.
- R5: For a non-branch instruction or a branch that is not taken, the IRQ is sampled in the cycle before the instruction's last cycle. If it is high and unmasked there, entry step 0 follows the last cycle directly.
- R6: An IRQ that first rises in an instruction's last cycle is not sampled until the next instruction's poll cycle.
- R7: On a branch that is not taken, an IRQ present in its first cycle causes entry right after its second cycle.
- R8: On a taken in-page branch, the only poll is its first cycle. An IRQ that first rises in the second or third cycle waits for the following instruction's poll. With a 7-cycle follower, entry starts 9 cycles after the IRQ first rises.
- R9: On a taken page-crossing branch, the poll is the third cycle. An IRQ present from the first or second cycle causes entry right after the fourth cycle.
- R10: An IRQ that is sampled while `irq_mask` is 1 is not taken.
- R11: Entry lasts 7 cycles with `entry_active` high and `entry_step` 0..6. `mask_set` is high only on step 6, and the next cycle is a fetch.
- R12: On a fetch cycle with `desc_valid` low and an unmasked IRQ high, entry starts on the next cycle.
- R13: `op_fetch` and `entry_active` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_valid | input | 1 | Descriptor is present |
| desc_ready | output | 1 | Descriptor can be taken (fetch cycle) |
| desc_cycles | input | 3 | Base cycle count of a non-branch instruction |
| desc_branch | input | 1 | Instruction is a conditional branch |
| desc_taken | input | 1 | Branch is taken |
| desc_xpage | input | 1 | Taken branch crosses a page |
| irq | input | 1 | Level-sensitive interrupt request, active high |
| irq_mask | input | 1 | Interrupt-disable flag |
| phase | output | 3 | Cycle index within the current instruction |
| op_fetch | output | 1 | Opcode-fetch strobe |
| entry_active | output | 1 | Interrupt entry sequence is running |
| entry_step | output | 3 | Step of the entry sequence, 0..6 |
| mask_set | output | 1 | Final entry step; the environment sets the disable flag |

## Verification
The main vectors pair each instruction shape with the cycle in which the IRQ first rises. The shapes are plain, branch not taken, taken in-page and taken page-crossing, and the IRQ rises in the first, second or third cycle. The vectors measure the cycle in which entry begins. Plain instructions with the IRQ in the penultimate or last cycle separate an on-time poll from a deferred one. Taken branches with the IRQ in the second cycle separate the in-page deferral from the page-cross case. A 7-cycle follower exposes the worst case. Directed tests cover clamping, the branch lengths, waiting without valid, masking, an IRQ on an idle fetch, and the step-by-step entry sequence.

// File: rtl/irq_poll_seq_pkg.sv
package irq_poll_seq_pkg;
  typedef enum logic [1:0] {
    SEQ_FETCH = 2'd0,
    SEQ_EXEC  = 2'd1,
    SEQ_ENTRY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/irq_poll_seq_decode.sv
module irq_poll_seq_decode #(
  parameter int MIN_CYC = 2,
  parameter int MAX_CYC = 7,
  parameter int CW = 3,
  parameter int PW = 3
) (
  input  logic [CW-1:0] base_cycles,
  input  logic          is_branch,
  input  logic          taken,
  input  logic          xpage,
  output logic [PW-1:0] last_ph,
  output logic [PW-1:0] poll_ph
);
  int len;

  always_comb begin
    if (is_branch) begin
      len = 2 + (taken ? 1 : 0) + ((taken && xpage) ? 1 : 0);
    end else if (int'(base_cycles) < MIN_CYC || int'(base_cycles) > MAX_CYC) begin
      len = MAX_CYC;
    end else begin
      len = int'(base_cycles);
    end
    last_ph = PW'(len - 1);
    // a taken in-page branch polls only on its first cycle
    if (is_branch && taken && !xpage) poll_ph = '0;
    else                              poll_ph = PW'(len - 2);
  end
endmodule

// File: rtl/irq_poll_seq_poll.sv
module irq_poll_seq_poll (
  input  logic clk,
  input  logic rst_n,
  input  logic sample,
  input  logic consume,
  input  logic irq,
  input  logic irq_mask,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pending <= 1'b0;
    else if (consume) pending <= 1'b0;
    else if (sample)  pending <= irq & ~irq_mask;
  end
endmodule

// File: rtl/irq_poll_seq_entry.sv
module irq_poll_seq_entry #(
  parameter int ENTRY_CYC = 7,
  parameter int SW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          active,
  output logic [SW-1:0] step,
  output logic          final_step
);
  assign final_step = active && (step == SW'(ENTRY_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      step   <= '0;
    end else if (start) begin
      active <= 1'b1;
      step   <= '0;
    end else if (final_step) begin
      active <= 1'b0;
      step   <= '0;
    end else if (active) begin
      step <= step + SW'(1);
    end
  end
endmodule

// File: rtl/irq_poll_seq.sv
module irq_poll_seq
  import irq_poll_seq_pkg::*;
#(
  parameter int MIN_CYC   = 2,
  parameter int MAX_CYC   = 7,
  parameter int ENTRY_CYC = 7,
  localparam int CW = $clog2(MAX_CYC + 1),
  localparam int PW = $clog2(MAX_CYC),
  localparam int SW = $clog2(ENTRY_CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          desc_valid,
  output logic          desc_ready,
  input  logic [CW-1:0] desc_cycles,
  input  logic          desc_branch,
  input  logic          desc_taken,
  input  logic          desc_xpage,
  input  logic          irq,
  input  logic          irq_mask,
  output logic [PW-1:0] phase,
  output logic          op_fetch,
  output logic          entry_active,
  output logic [SW-1:0] entry_step,
  output logic          mask_set
);
  seq_state_e  state_q;
  logic [PW-1:0] phase_q, last_q, poll_q;
  logic [PW-1:0] dec_last, dec_poll;
  logic accept, at_last, idle_take, sample, pending, start_entry, entry_done;

  irq_poll_seq_decode #(
    .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CW(CW), .PW(PW)
  ) dec_i (
    .base_cycles(desc_cycles), .is_branch(desc_branch), .taken(desc_taken),
    .xpage(desc_xpage), .last_ph(dec_last), .poll_ph(dec_poll)
  );

  assign op_fetch   = (state_q == SEQ_FETCH);
  assign desc_ready = op_fetch;
  assign accept     = op_fetch && desc_valid;
  assign at_last    = (state_q == SEQ_EXEC) && (phase_q == last_q);
  assign idle_take  = op_fetch && !desc_valid && irq && !irq_mask;
  assign sample     = (accept && dec_poll == '0) ||
                      ((state_q == SEQ_EXEC) && (phase_q == poll_q));
  assign start_entry = (at_last && pending) || idle_take;

  irq_poll_seq_poll poll_i (
    .clk(clk), .rst_n(rst_n), .sample(sample), .consume(at_last),
    .irq(irq), .irq_mask(irq_mask), .pending(pending)
  );

  irq_poll_seq_entry #(.ENTRY_CYC(ENTRY_CYC), .SW(SW)) entry_i (
    .clk(clk), .rst_n(rst_n), .start(start_entry), .active(entry_active),
    .step(entry_step), .final_step(entry_done)
  );

  assign mask_set = entry_done;
  assign phase    = phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_FETCH;
      phase_q <= '0;
      last_q  <= '0;
      poll_q  <= '0;
    end else begin
      unique case (state_q)
        SEQ_FETCH: begin
          if (accept) begin
            state_q <= SEQ_EXEC;
            phase_q <= PW'(1);
            last_q  <= dec_last;
            poll_q  <= dec_poll;
          end else if (idle_take) begin
            state_q <= SEQ_ENTRY;
          end
        end
        SEQ_EXEC: begin
          if (at_last) begin
            state_q <= pending ? SEQ_ENTRY : SEQ_FETCH;
            phase_q <= '0;
          end else begin
            phase_q <= phase_q + PW'(1);
          end
        end
        SEQ_ENTRY: begin
          if (entry_done) state_q <= SEQ_FETCH;
        end
        default: state_q <= SEQ_FETCH;
      endcase
    end
  end
endmodule

// File: rtl/irq_poll_seq_chk.sv
module irq_poll_seq_chk #(
  parameter int MAX_CYC   = 7,
  parameter int ENTRY_CYC = 7,
  parameter int PW = 3,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic          op_fetch,
  input logic [PW-1:0] phase,
  input logic          entry_active,
  input logic [SW-1:0] entry_step,
  input logic          mask_set
);
  // R13
  fetch_entry_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_fetch && entry_active));

  // R11
  entry_step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_active && entry_step != SW'(ENTRY_CYC - 1)) |=>
      (entry_active && entry_step == $past(entry_step) + SW'(1)));

  // R11
  entry_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_active && mask_set) |=> (!entry_active && op_fetch));

  // R11
  entry_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(entry_active) |-> (entry_step == '0));

  // R2
  accept_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> (!op_fetch && phase == PW'(1)));

  // R2
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fetch && !desc_valid) |=> (phase == '0));

  // R3
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(phase) < MAX_CYC);
endmodule

bind irq_poll_seq irq_poll_seq_chk #(
  .MAX_CYC(MAX_CYC), .ENTRY_CYC(ENTRY_CYC), .PW(PW), .SW(SW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
  .op_fetch(op_fetch), .phase(phase), .entry_active(entry_active),
  .entry_step(entry_step), .mask_set(mask_set)
);

// File: tb/irq_poll_seq_tb_top.sv
module irq_poll_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic desc_valid = 1'b0, desc_branch = 1'b0, desc_taken = 1'b0, desc_xpage = 1'b0;
  logic [2:0] desc_cycles = 3'd2;
  logic irq = 1'b0, irq_mask = 1'b0;
  logic desc_ready, op_fetch, entry_active, mask_set;
  logic [2:0] phase, entry_step;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_poll_seq dut_i (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_cycles(desc_cycles), .desc_branch(desc_branch), .desc_taken(desc_taken),
    .desc_xpage(desc_xpage), .irq(irq), .irq_mask(irq_mask), .phase(phase),
    .op_fetch(op_fetch), .entry_active(entry_active), .entry_step(entry_step),
    .mask_set(mask_set)
  );

  // {req[21:18], cycles[17:15], br[14], tk[13], xp[12], irq_at[11:8], follower[7:5], entry_cycle[4:0]}
  localparam logic [21:0] VECS [0:12] = '{
    {4'd5, 3'd4, 1'b0, 1'b0, 1'b0, 4'd2, 3'd2, 5'd4},  // R5 penultimate poll
    {4'd6, 3'd4, 1'b0, 1'b0, 1'b0, 4'd3, 3'd2, 5'd6},  // R6 rises in last cycle
    {4'd7, 3'd2, 1'b1, 1'b0, 1'b0, 4'd0, 3'd2, 5'd2},  // R7 not taken, first cycle
    {4'd6, 3'd2, 1'b1, 1'b0, 1'b0, 4'd1, 3'd3, 5'd5},  // R6 not taken, second cycle
    {4'd8, 3'd2, 1'b1, 1'b1, 1'b0, 4'd0, 3'd2, 5'd3},  // R8 in-page, first cycle
    {4'd8, 3'd2, 1'b1, 1'b1, 1'b0, 4'd1, 3'd7, 5'd10}, // R8 worst case, 7-cycle follower
    {4'd8, 3'd2, 1'b1, 1'b1, 1'b0, 4'd2, 3'd2, 5'd5},  // R8 third cycle
    {4'd9, 3'd2, 1'b1, 1'b1, 1'b1, 4'd1, 3'd2, 5'd4},  // R9 cross, second cycle
    {4'd9, 3'd2, 1'b1, 1'b1, 1'b1, 4'd0, 3'd2, 5'd4},  // R9 cross, first cycle
    {4'd3, 3'd0, 1'b0, 1'b0, 1'b0, 4'd5, 3'd2, 5'd7},  // R3 count 0 clamps to 7
    {4'd3, 3'd1, 1'b0, 1'b0, 1'b0, 4'd5, 3'd2, 5'd7},  // R3 count 1 clamps to 7
    {4'd3, 3'd7, 1'b0, 1'b0, 1'b0, 4'd5, 3'd2, 5'd7},  // R3 count 7 kept
    {4'd5, 3'd2, 1'b0, 1'b0, 1'b0, 4'd0, 3'd2, 5'd2}   // R5 two-cycle plain
  };

  task automatic check(input bit ok, input int req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input logic [21:0] v);
    int found = -1;
    for (int k = 0; k < 24 && found < 0; k++) begin
      if (entry_active) found = k;
      else begin
        irq = (k >= int'(v[11:8]));
        desc_valid = op_fetch;
        if (k == 0) begin
          desc_cycles = v[17:15]; desc_branch = v[14]; desc_taken = v[13]; desc_xpage = v[12];
        end else begin
          desc_cycles = v[7:5]; desc_branch = 1'b0; desc_taken = 1'b0; desc_xpage = 1'b0;
        end
        @(negedge clk);
      end
    end
    desc_valid = 1'b0;
    check(found == int'(v[4:0]), int'(v[21:18]), found, int'(v[4:0]));
    if (found >= 0) begin
      while (!mask_set) @(negedge clk);
      irq_mask = 1'b1; irq = 1'b0;
      @(negedge clk);
      irq_mask = 1'b0;
    end else begin
      irq = 1'b0;
      while (!op_fetch) @(negedge clk);
    end
  endtask

  task automatic measure_len(input logic [2:0] c, input logic br, input logic tk,
                             input logic xp, input int req, input int exp);
    int n = 0;
    desc_cycles = c; desc_branch = br; desc_taken = tk; desc_xpage = xp; desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    n = 1;
    while (!op_fetch && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == exp, req, n, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R13 watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(op_fetch && desc_ready && !entry_active && !mask_set && phase == 0 && entry_step == 0,
          1, {op_fetch, desc_ready, entry_active, mask_set}, 4'b1100);

    // R2 no valid: fetch repeats
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(op_fetch && phase == 0, 2, {op_fetch, phase}, 4'b1000);
    end

    // R3 phase sequence of a 5-cycle instruction
    desc_cycles = 3'd5; desc_branch = 1'b0; desc_taken = 1'b0; desc_xpage = 1'b0; desc_valid = 1'b1;
    for (int k = 0; k < 6; k++) begin
      check(int'(phase) == (k % 5) && op_fetch == (k % 5 == 0), 3, int'(phase), k % 5);
      @(negedge clk);
      desc_valid = 1'b0;
    end

    // R4 branch lengths (desc_cycles ignored)
    measure_len(3'd6, 1'b1, 1'b0, 1'b0, 4, 2);
    measure_len(3'd6, 1'b1, 1'b1, 1'b0, 4, 3);
    measure_len(3'd6, 1'b1, 1'b1, 1'b1, 4, 4);
    measure_len(3'd1, 1'b1, 1'b0, 1'b1, 4, 2);

    // R3 R5 R6 R7 R8 R9 timing table
    foreach (VECS[i]) run_vec(VECS[i]);

    // R10 masked IRQ is not taken
    irq_mask = 1'b1; irq = 1'b1;
    begin
      int seen = 0;
      desc_cycles = 3'd3; desc_branch = 1'b0; desc_valid = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        desc_valid = 1'b0;
        if (entry_active) seen++;
      end
      check(seen == 0, 10, seen, 0);
    end
    irq = 1'b0;
    @(negedge clk);
    irq_mask = 1'b0;

    // R12 idle fetch with IRQ
    irq = 1'b1;
    @(negedge clk);
    check(entry_active && entry_step == 0, 12, {entry_active, entry_step}, 4'b1000);
    // R11 entry steps
    for (int s = 0; s < 7; s++) begin
      check(entry_active && int'(entry_step) == s && !op_fetch && mask_set == (s == 6),
            11, int'(entry_step), s);
      if (s == 6) begin irq_mask = 1'b1; irq = 1'b0; end
      @(negedge clk);
    end
    // R13 fetch resumes after entry
    check(op_fetch && !entry_active, 13, {op_fetch, entry_active}, 2'b10);
    irq_mask = 1'b0;
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule